// File: doc/BRIEF.md
# Translation Buffer Invalidation Matcher

A fully associative translation buffer with a parameterised number of entries (16 by default). Each entry holds a valid flag and a 52-bit page number. It also holds a page size code, a segment size code, a partition ID, a process ID and a process-scoped flag. Entries are loaded through a write port. The buffer contents are visible as a vector of valid bits.

An invalidate request carries a 64-bit address operand and a 64-bit register operand. The register operand holds the process ID in its upper half and the partition ID in its lower half. The request also carries a 2-bit control field, a process-scoped bit and an effective-address bit. The block decodes which invalidation scope the request selects: one page named by a virtual page number, one page named by an effective address, an aligned group of pages, or every page of a process. It compares all entries in parallel, clears each entry that matches, and then pulses a done flag. Requests use a valid/ready handshake, and only one request is in flight at a time.

Bit positions below are LSB-first (bit 63 is the MSB) and use these names for address-operand fields: `pn` = [63:12], `scope` = [11:10], `seg` = [9:8], `pgc` = [7:5], `gsz` = [7:6], `lbit` = [0]. Page size codes: 0 = 4 KiB, 1 = 64 KiB, 2 = 2 MiB, 3 = 1 GiB; codes 4 to 7 match nothing.

Top module: `tlb_inval_unit`

## Requirements
- R1: After reset, every entry is invalid, `req_ready_o` is 1 and `done_o` is 0.
- R2: A write with `wr_en_i`=1 on a clock edge where `req_ready_o`=1 loads entry `wr_idx_i`; its valid bit follows `wr_valid_i` on `valid_o` after that edge. Writes on edges where `req_ready_o`=0 are ignored.
- R3: A request is taken on the edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is then 0 for two cycles. `done_o` is 1 for exactly the second of those cycles, and the cleared valid bits show on `valid_o` in that same cycle. Valid bits never fall at any other time.
- R4: The matching partition ID is `req_rs_i[31:0]` when `hv_i`=1 at acceptance, and `local_lpid_i` otherwise.
- R5: With scope 0, control 0, effective bit 0 and `lbit`=0, the compare value is `pn`. An entry is cleared when it is valid and non-process-scoped, its segment code equals `seg`, its partition ID matches, and its page number equals the compare value in every bit above the entry's own page size.
- R6: In the R5 case with `lbit`=1, the compare value is {addr[63:20], addr[7:1], 0}.
- R7: With scope 0, control 0 and effective bit 1, `pgc` gives the request page size. An entry is cleared when its page size code equals `pgc` and its page number equals `pn` in every bit above that size, with the partition filter applied.
- R8: In the R7 case, the entry's process-scoped flag must equal `req_prs_i`. When `req_prs_i`=1, the entry's process ID must also equal `req_rs_i[63:32]`.
- R9: A request page size code of 4 to 7 clears no entry.
- R10: With scope 0 and control 3, `gsz`=0 selects sixteen 4 KiB pages and `gsz`=1 selects sixteen 64 KiB pages; `gsz` of 2 or 3 clears nothing. Every valid, non-process-scoped entry with that page size, segment code `seg`, a matching partition ID and a page number inside the 16-page aligned group containing `pn` is cleared.
- R11: With scope 1 and control 0 or 2, every valid entry that is process-scoped, has a matching partition ID and has process ID `req_rs_i[63:32]` is cleared.
- R12: Any other combination of scope and control completes with a done pulse and leaves every entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Invalidate request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_addr_i | input | 64 | Address operand |
| req_rs_i | input | 64 | Process ID [63:32], partition ID [31:0] |
| req_ctl_i | input | 2 | Invalidation control |
| req_prs_i | input | 1 | Process-scoped request |
| req_effr_i | input | 1 | Effective-address form select |
| hv_i | input | 1 | Take partition ID from register operand |
| local_lpid_i | input | 32 | Locally held partition ID |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W (4) | Entry index |
| wr_valid_i | input | 1 | Valid bit to write |
| wr_pn_i | input | 52 | Page number |
| wr_pg_i | input | 3 | Page size code |
| wr_seg_i | input | 2 | Segment size code |
| wr_lpid_i | input | 32 | Partition ID |
| wr_pid_i | input | 32 | Process ID |
| wr_prs_i | input | 1 | Process-scoped flag |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | ENTRIES (16) | Valid bit of each entry |

## Verification
An entry write appears on `valid_o` one rising edge after it is driven. An invalidate result, which is the done pulse together with the updated valid vector, is due on the second rising edge after the accepting edge. The bench drives inputs on falling edges. For each request its driver task pushes the expected valid vector into a queue. A monitor pops that vector on the falling edge where `done_o` is high and compares it with `valid_o`. One directed sequence also samples `req_ready_o` and `done_o` on each falling edge between acceptance and return to idle, with a write driven into the busy window.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;
  localparam int unsigned ADDR_W    = 64;
  localparam int unsigned PN_W      = 52;
  localparam int unsigned ID_W      = 32;
  localparam int unsigned PG_W      = 3;
  localparam int unsigned SEG_W     = 2;
  localparam int unsigned RANGE_LOG = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DONE} state_e;
  typedef enum logic [2:0] {MODE_NONE, MODE_VA, MODE_EA, MODE_RANGE, MODE_PID} mode_e;

  typedef struct packed {
    logic             vld;
    logic [PN_W-1:0]  pn;
    logic [PG_W-1:0]  pg;
    logic [SEG_W-1:0] seg;
    logic [ID_W-1:0]  lpid;
    logic [ID_W-1:0]  pid;
    logic             prs;
  } entry_t;

  typedef struct packed {
    mode_e            mode;
    logic [PN_W-1:0]  pn;
    logic [PN_W-1:0]  mask;
    logic [PG_W-1:0]  pg;
    logic             pg_ok;
    logic [SEG_W-1:0] seg;
    logic [ID_W-1:0]  lpid;
    logic [ID_W-1:0]  pid;
    logic             prs;
  } cmd_t;

  // page-number bits kept above page size, extra low bits dropped for groups
  function automatic logic [PN_W-1:0] pg_mask(logic [PG_W-1:0] code, int unsigned extra);
    int unsigned sh;
    logic [PN_W-1:0] m;
    case (code)
      3'd0:    sh = 0;
      3'd1:    sh = 4;
      3'd2:    sh = 9;
      default: sh = 18;
    endcase
    m = '1;
    return m << (sh + extra);
  endfunction

  function automatic logic pg_known(logic [PG_W-1:0] code);
    return !code[PG_W-1];
  endfunction
endpackage

// File: rtl/tlb_inval_decode.sv
module tlb_inval_decode import tlb_inval_pkg::*; #(
  parameter int unsigned GRP_LOG = RANGE_LOG
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [1:0]        ctl_i,
  input  logic              prs_i,
  input  logic              effr_i,
  input  logic [ID_W-1:0]   lpid_i,
  output cmd_t              cmd_o
);
  logic [1:0]      scope;
  logic [1:0]      gsz;
  logic [PG_W-1:0] pgc;
  logic            lbit;

  assign scope = addr_i[11:10];
  assign pgc   = addr_i[7:5];
  assign gsz   = addr_i[7:6];
  assign lbit  = addr_i[0];

  always_comb begin
    cmd_o       = '0;
    cmd_o.mode  = MODE_NONE;
    cmd_o.pn    = addr_i[63:12];
    cmd_o.mask  = '1;
    cmd_o.pg    = pgc;
    cmd_o.pg_ok = pg_known(pgc);
    cmd_o.seg   = addr_i[9:8];
    cmd_o.lpid  = lpid_i;
    cmd_o.pid   = rs_i[63:32];
    cmd_o.prs   = prs_i;
    if (scope == 2'd0) begin
      if (ctl_i == 2'd0) begin
        if (!effr_i) begin
          cmd_o.mode = MODE_VA;
          if (lbit) cmd_o.pn = {addr_i[63:20], addr_i[7:1], 1'b0};
        end else begin
          cmd_o.mode = MODE_EA;
          cmd_o.mask = pg_mask(pgc, 0);
        end
      end else if (ctl_i == 2'd3) begin
        cmd_o.mode  = MODE_RANGE;
        cmd_o.pg    = {{(PG_W-1){1'b0}}, gsz[0]};
        cmd_o.pg_ok = !gsz[1];
        cmd_o.mask  = pg_mask({{(PG_W-1){1'b0}}, gsz[0]}, GRP_LOG);
      end
    end else if (scope == 2'd1 && (ctl_i == 2'd0 || ctl_i == 2'd2)) begin
      cmd_o.mode = MODE_PID;
    end
  end
endmodule

// File: rtl/tlb_inval_match.sv
module tlb_inval_match import tlb_inval_pkg::*; (
  input  cmd_t   cmd_i,
  input  entry_t ent_i,
  output logic   hit_o
);
  logic [PN_W-1:0] diff;
  logic lpid_eq, pid_eq, pn_req_eq, pn_ent_eq, pg_eq;

  assign diff      = ent_i.pn ^ cmd_i.pn;
  assign lpid_eq   = ent_i.lpid == cmd_i.lpid;
  assign pid_eq    = ent_i.pid == cmd_i.pid;
  assign pn_req_eq = (diff & cmd_i.mask) == '0;
  assign pn_ent_eq = (diff & pg_mask(ent_i.pg, 0)) == '0;
  assign pg_eq     = cmd_i.pg_ok && (ent_i.pg == cmd_i.pg);

  always_comb begin
    unique case (cmd_i.mode)
      MODE_VA:    hit_o = pg_known(ent_i.pg) && pn_ent_eq && (ent_i.seg == cmd_i.seg)
                          && lpid_eq && !ent_i.prs;
      MODE_EA:    hit_o = pg_eq && pn_req_eq && lpid_eq && (ent_i.prs == cmd_i.prs)
                          && (!cmd_i.prs || pid_eq);
      MODE_RANGE: hit_o = pg_eq && pn_req_eq && (ent_i.seg == cmd_i.seg)
                          && lpid_eq && !ent_i.prs;
      MODE_PID:   hit_o = lpid_eq && pid_eq && ent_i.prs;
      default:    hit_o = 1'b0;
    endcase
    hit_o = hit_o && ent_i.vld;
  end
endmodule

// File: rtl/tlb_inval_unit.sv
module tlb_inval_unit import tlb_inval_pkg::*; #(
  parameter  int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [ADDR_W-1:0]  req_rs_i,
  input  logic [1:0]         req_ctl_i,
  input  logic               req_prs_i,
  input  logic               req_effr_i,
  input  logic               hv_i,
  input  logic [ID_W-1:0]    local_lpid_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_valid_i,
  input  logic [PN_W-1:0]    wr_pn_i,
  input  logic [PG_W-1:0]    wr_pg_i,
  input  logic [SEG_W-1:0]   wr_seg_i,
  input  logic [ID_W-1:0]    wr_lpid_i,
  input  logic [ID_W-1:0]    wr_pid_i,
  input  logic               wr_prs_i,
  output logic               done_o,
  output logic [ENTRIES-1:0] valid_o
);
  state_e             state_q;
  logic [ADDR_W-1:0]  addr_q, rs_q;
  logic [1:0]         ctl_q;
  logic               prs_q, effr_q;
  logic [ID_W-1:0]    lpid_q;
  cmd_t               cmd;
  logic [ENTRIES-1:0] hit;
  logic               accept, wr_ok, clr;
  entry_t             wr_ent;

  assign req_ready_o = state_q == ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign accept      = req_valid_i && req_ready_o;
  assign wr_ok       = wr_en_i && req_ready_o;
  assign clr         = state_q == ST_EVAL;
  assign wr_ent      = '{vld: wr_valid_i, pn: wr_pn_i, pg: wr_pg_i, seg: wr_seg_i,
                         lpid: wr_lpid_i, pid: wr_pid_i, prs: wr_prs_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rs_q    <= '0;
      ctl_q   <= '0;
      prs_q   <= 1'b0;
      effr_q  <= 1'b0;
      lpid_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_EVAL;
        ST_EVAL: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
      if (accept) begin
        addr_q <= req_addr_i;
        rs_q   <= req_rs_i;
        ctl_q  <= req_ctl_i;
        prs_q  <= req_prs_i;
        effr_q <= req_effr_i;
        lpid_q <= hv_i ? req_rs_i[ID_W-1:0] : local_lpid_i;
      end
    end
  end

  tlb_inval_decode #(.GRP_LOG(RANGE_LOG)) u_dec (
    .addr_i(addr_q), .rs_i(rs_q), .ctl_i(ctl_q), .prs_i(prs_q),
    .effr_i(effr_q), .lpid_i(lpid_q), .cmd_o(cmd)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    entry_t ent_q;

    tlb_inval_match u_match (.cmd_i(cmd), .ent_i(ent_q), .hit_o(hit[g]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ent_q     <= '0;
      else if (wr_ok && wr_idx_i == IDX_W'(g))     ent_q     <= wr_ent;
      else if (clr && hit[g])                      ent_q.vld <= 1'b0;
    end

    assign valid_o[g] = ent_q.vld;
  end
endmodule

// File: rtl/tlb_inval_chk.sv
module tlb_inval_chk #(
  parameter int unsigned ENTRIES = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               done_o,
  input logic [ENTRIES-1:0] valid_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_ready_o); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o && !done_o); // R3
  AST_ACCEPT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ##1 done_o); // R3
  AST_CLEAR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(valid_o) & ~valid_o)) |-> done_o); // R3
  AST_SET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(valid_o & ~$past(valid_o))) |-> $past(req_ready_o)); // R2
endmodule

bind tlb_inval_unit tlb_inval_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .done_o(done_o), .valid_o(valid_o)
);

// File: tb/sim_tlb_inval_unit.sv
`timescale 1ns/1ps
module sim_tlb_inval_unit;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, req_prs_i = 0, req_effr_i = 0, hv_i = 0;
  logic [63:0] req_addr_i = '0, req_rs_i = '0;
  logic [1:0]  req_ctl_i = '0;
  logic [31:0] local_lpid_i = 32'h11;
  logic        wr_en_i = 0, wr_valid_i = 0, wr_prs_i = 0;
  logic [3:0]  wr_idx_i = '0;
  logic [51:0] wr_pn_i = '0;
  logic [2:0]  wr_pg_i = '0;
  logic [1:0]  wr_seg_i = '0;
  logic [31:0] wr_lpid_i = '0, wr_pid_i = '0;
  logic        req_ready_o, done_o;
  logic [15:0] valid_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tlb_inval_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_rs_i(req_rs_i), .req_ctl_i(req_ctl_i),
    .req_prs_i(req_prs_i), .req_effr_i(req_effr_i), .hv_i(hv_i),
    .local_lpid_i(local_lpid_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_valid_i(wr_valid_i), .wr_pn_i(wr_pn_i), .wr_pg_i(wr_pg_i), .wr_seg_i(wr_seg_i),
    .wr_lpid_i(wr_lpid_i), .wr_pid_i(wr_pid_i), .wr_prs_i(wr_prs_i),
    .done_o(done_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_addr(input logic [51:0] pn, input logic [1:0] scope,
                                          input logic [1:0] seg, input logic [7:0] lo);
    return {pn, scope, seg, lo};
  endfunction

  task automatic wr_ent(input int idx, input logic [51:0] pn, input logic [2:0] pg,
                        input logic [1:0] seg, input logic [31:0] lpid,
                        input logic [31:0] pid, input logic prs);
    @(negedge clk);
    wr_en_i = 1; wr_idx_i = 4'(idx); wr_valid_i = 1; wr_pn_i = pn; wr_pg_i = pg;
    wr_seg_i = seg; wr_lpid_i = lpid; wr_pid_i = pid; wr_prs_i = prs;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic inv(input logic [63:0] addr, input logic [63:0] rs, input logic [1:0] ctl,
                     input logic prs, input logic effr, input logic hv,
                     input logic [15:0] exp, input string tag);
    @(negedge clk);
    req_valid_i = 1; req_addr_i = addr; req_rs_i = rs; req_ctl_i = ctl;
    req_prs_i = prs; req_effr_i = effr; hv_i = hv;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid_i = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: result due with done, two edges after acceptance
  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected done", 64'(valid_o), 64'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(valid_o == e, t, 64'(valid_o), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 64'h0, 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(valid_o == 16'h0, "R1 valid", 64'(valid_o), 64'h0);
    chk(req_ready_o == 1'b1, "R1 ready", 64'(req_ready_o), 64'h1);
    chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'h0);

    // R5: virtual page form, entry-size mask
    wr_ent(0, 52'h12345, 3'd0, 2'd0, 32'h11, 32'h0, 1'b0);
    wr_ent(1, 52'h12345, 3'd0, 2'd1, 32'h11, 32'h0, 1'b0);
    wr_ent(2, 52'h12345, 3'd0, 2'd0, 32'h11, 32'h0, 1'b1);
    wr_ent(3, 52'h12345, 3'd0, 2'd0, 32'h22, 32'h0, 1'b0);
    wr_ent(4, 52'h12346, 3'd0, 2'd0, 32'h11, 32'h0, 1'b0);
    wr_ent(5, 52'h12340, 3'd1, 2'd0, 32'h11, 32'h0, 1'b0);
    chk(valid_o == 16'h003F, "R2 fill", 64'(valid_o), 64'h3F);
    inv(mk_addr(52'h12345, 2'd0, 2'd0, 8'h00), {32'h0, 32'h11}, 2'd0, 0, 0, 1, 16'h001E, "R5 va");

    // R6 + R4: L form, local partition (hv=0 ignores rs partition 0x22)
    wr_ent(6, 52'hABC00, 3'd2, 2'd0, 32'h11, 32'h0, 1'b0);
    wr_ent(7, 52'hABC5A, 3'd0, 2'd0, 32'h11, 32'h0, 1'b0);
    chk(valid_o == 16'h00DE, "R2 fill", 64'(valid_o), 64'hDE);
    inv({44'hABC, 8'hFF, 2'd0, 2'd0, 8'h5B}, {32'h0, 32'h22}, 2'd0, 0, 0, 0, 16'h001E, "R6 R4 lform");

    // R7/R8: effective form
    wr_ent(8,  52'h77773, 3'd1, 2'd0, 32'h11, 32'h55, 1'b1);
    wr_ent(9,  52'h77773, 3'd1, 2'd0, 32'h11, 32'h56, 1'b1);
    wr_ent(10, 52'h77773, 3'd0, 2'd0, 32'h11, 32'h55, 1'b1);
    wr_ent(11, 52'h77773, 3'd1, 2'd0, 32'h11, 32'h55, 1'b0);
    chk(valid_o == 16'h0F1E, "R2 fill", 64'(valid_o), 64'hF1E);
    inv(mk_addr(52'h77770, 2'd0, 2'd0, 8'h20), {32'h55, 32'h11}, 2'd0, 1, 1, 1, 16'h0E1E, "R7 R8 ea prs1");
    inv(mk_addr(52'h77771, 2'd0, 2'd0, 8'h20), {32'h99, 32'h11}, 2'd0, 0, 1, 1, 16'h061E, "R8 ea prs0");
    inv(mk_addr(52'h77770, 2'd0, 2'd0, 8'hA0), {32'h56, 32'h11}, 2'd0, 1, 1, 1, 16'h061E, "R9 reserved");

    // R10: aligned page groups
    wr_ent(12, 52'h50003, 3'd0, 2'd2, 32'h11, 32'h0, 1'b0);
    wr_ent(13, 52'h5000F, 3'd0, 2'd2, 32'h11, 32'h0, 1'b0);
    wr_ent(14, 52'h50010, 3'd0, 2'd2, 32'h11, 32'h0, 1'b0);
    wr_ent(15, 52'h50005, 3'd1, 2'd2, 32'h11, 32'h0, 1'b0);
    chk(valid_o == 16'hF61E, "R2 fill", 64'(valid_o), 64'hF61E);
    inv(mk_addr(52'h50007, 2'd0, 2'd2, 8'h00), {32'h0, 32'h11}, 2'd3, 0, 0, 1, 16'hC61E, "R10 4k group");
    inv(mk_addr(52'h500A0, 2'd0, 2'd2, 8'h40), {32'h0, 32'h11}, 2'd3, 0, 0, 1, 16'h461E, "R10 64k group");

    // R11: process scope
    inv(mk_addr(52'h0, 2'd1, 2'd0, 8'h00), {32'h55, 32'h11}, 2'd0, 0, 0, 1, 16'h421E, "R11 ctl0");
    inv(mk_addr(52'h0, 2'd1, 2'd0, 8'h00), {32'h0, 32'h11}, 2'd2, 0, 0, 1, 16'h421A, "R11 ctl2");

    // R12: unlisted combinations
    inv(mk_addr(52'h0, 2'd1, 2'd0, 8'h00), {32'h56, 32'h11}, 2'd1, 0, 0, 1, 16'h421A, "R12 scope1 ctl1");
    inv(mk_addr(52'h12346, 2'd0, 2'd0, 8'h00), {32'h0, 32'h11}, 2'd1, 0, 0, 1, 16'h421A, "R12 scope0 ctl1");
    inv(mk_addr(52'h0, 2'd3, 2'd0, 8'h00), {32'h56, 32'h11}, 2'd0, 0, 0, 1, 16'h421A, "R12 scope3");

    // R3 handshake timing, R2 write ignored while busy
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R3 ready idle", 64'(req_ready_o), 64'h1);
    req_valid_i = 1; req_addr_i = mk_addr(52'h0, 2'd2, 2'd0, 8'h00); req_ctl_i = 2'd0;
    exp_q.push_back(16'h421A); tag_q.push_back("R12 scope2");
    @(negedge clk);
    req_valid_i = 0;
    chk(req_ready_o == 1'b0, "R3 busy ready", 64'(req_ready_o), 64'h0);
    chk(done_o == 1'b0, "R3 early done", 64'(done_o), 64'h0);
    wr_en_i = 1; wr_idx_i = 4'd0; wr_valid_i = 1; wr_pn_i = 52'h1; wr_pg_i = 3'd0;
    @(negedge clk);
    wr_en_i = 0;
    chk(done_o == 1'b1, "R3 done due", 64'(done_o), 64'h1);
    chk(req_ready_o == 1'b0, "R3 ready during done", 64'(req_ready_o), 64'h0);
    @(negedge clk);
    chk(done_o == 1'b0, "R3 done width", 64'(done_o), 64'h0);
    chk(req_ready_o == 1'b1, "R3 ready back", 64'(req_ready_o), 64'h1);
    chk(valid_o[0] == 1'b0, "R2 busy write ignored", 64'(valid_o[0]), 64'h0);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 missing done", 64'(exp_q.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule